// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is a 32-pin general-purpose I/O bank controlled over a simple single-cycle register bus. The block holds an output level and a direction for every pin. It drives the pad output values and pad output enables directly from that state. Each control word covers only sixteen pins. The upper halfword of a write works as a per-bit enable mask for the lower halfword, so software can set or clear any subset of pins in a single write. No read-modify-write sequence is needed, and no lock is needed between agents that share the bank.

The pad input levels pass through a two-stage synchronizer and can be read back together as one 32-bit word. A fixed, nonzero identifier lets software tell this register layout apart from an older layout that returns zero at the same offset. To turn a pin into an output without a glitch, software writes the level first and then sets the direction bit.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, all level and direction bits are 0, so every pad output enable is low and every pad output value is low.
- R2: A write to offset 0x00 updates the levels of pins 0..15. Bit k (k < 16) of the level changes to wdata[k] only when wdata[16+k] is 1.
- R3: A write to offset 0x04 updates the levels of pins 16..31 in the same masked way. Bit k of the data word maps to pin 16+k.
- R4: Writes to offsets 0x08 (pins 0..15) and 0x0C (pins 16..31) update the direction bits in the same masked way. A direction bit of 1 means the pin is an output.
- R5: A state bit whose enable bit (wdata[16+k]) is 0 keeps its value. A write with an all-zero upper halfword changes nothing.
- R6: The pad output value of each pin equals its level bit, and the pad output enable equals its direction bit. Both follow a write on the next clock edge.
- R7: A read of offset 0x00, 0x04, 0x08 or 0x0C returns the sixteen state bits in rdata[15:0] and zero in rdata[31:16]. Read data is combinational in the same cycle as the address.
- R8: A read of offset 0x70 returns the pad input levels after two synchronizer flops. A pad change that is present before edge n shows in the read after edge n+1 and not after edge n.
- R9: A read of offset 0x78 returns the parameter VERSION_ID, which must be nonzero (default 0x0101_157C).
- R10: A read of any other offset returns zero. Writes to 0x70, to 0x78 or to any unmapped offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data: upper halfword is the mask, lower halfword is the values |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busRdata | output | 32 | Combinational read data |
| padIn | input | 32 | Pad input levels (asynchronous) |
| padOut | output | 32 | Pad output values |
| padOe | output | 32 | Pad output enables |

## Verification
State lives only in the level and direction registers and in the synchronizer. A wrong mask decode or a wrong half selection therefore shows on padOut or padOe one edge after the offending write. The same error shows in the register readback in that same cycle. Bus writes of distinct masks and halves are each checked at the pads and through the bus. A synchronizer of the wrong depth shifts the pad read by a cycle, and the bench checks the exact edge at which the new level appears.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int PINS  = 32;
  localparam int HALF  = PINS / 2;
  localparam int AW    = 8;

  localparam logic [AW-1:0] OFF_LVL_LO = 8'h00;
  localparam logic [AW-1:0] OFF_LVL_HI = 8'h04;
  localparam logic [AW-1:0] OFF_DIR_LO = 8'h08;
  localparam logic [AW-1:0] OFF_DIR_HI = 8'h0C;
  localparam logic [AW-1:0] OFF_PORT   = 8'h70;
  localparam logic [AW-1:0] OFF_IDENT  = 8'h78;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LVL_LO, SEL_LVL_HI, SEL_DIR_LO, SEL_DIR_HI, SEL_PORT, SEL_IDENT
  } regSel_e;

  typedef struct packed {
    logic [3:0] wrHalf;   // one-hot: lvlLo, lvlHi, dirLo, dirHi
    regSel_e    rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  output ctrlStrobe_t   strobe
);
  regSel_e sel;

  always_comb begin
    unique case (busAddr)
      OFF_LVL_LO: sel = SEL_LVL_LO;
      OFF_LVL_HI: sel = SEL_LVL_HI;
      OFF_DIR_LO: sel = SEL_DIR_LO;
      OFF_DIR_HI: sel = SEL_DIR_HI;
      OFF_PORT:   sel = SEL_PORT;
      OFF_IDENT:  sel = SEL_IDENT;
      default:    sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.rdSel  = sel;
    strobe.wrHalf = '0;
    if (busWe) begin
      case (sel)
        SEL_LVL_LO: strobe.wrHalf[0] = 1'b1;
        SEL_LVL_HI: strobe.wrHalf[1] = 1'b1;
        SEL_DIR_LO: strobe.wrHalf[2] = 1'b1;
        SEL_DIR_HI: strobe.wrHalf[3] = 1'b1;
        default:    strobe.wrHalf    = '0;
      endcase
    end
  end

  // R10: read-only and unmapped offsets never raise a write strobe
  a_r10_no_strobe_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == OFF_PORT || busAddr == OFF_IDENT) |-> strobe.wrHalf == '0);
  a_r4_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe.wrHalf));
endmodule

// File: rtl/gpio_mask_datapath.sv
module gpio_mask_datapath
  import gpio_mask_pkg::*;
#(
  parameter logic [31:0] VERSION_ID = 32'h0101_157C
)(
  input  logic            clk,
  input  logic            rst_n,
  input  ctrlStrobe_t     strobe,
  input  logic [31:0]     busWdata,
  input  logic [PINS-1:0] padIn,
  output logic [31:0]     busRdata,
  output logic [PINS-1:0] lvlQ,
  output logic [PINS-1:0] dirQ
);
  logic [PINS-1:0] syncA, syncB;
  logic [HALF-1:0] wMask, wVal;

  assign wMask = busWdata[31:HALF];
  assign wVal  = busWdata[HALF-1:0];

  // masked update per halfword; generate over the two halves
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvlQ[h*HALF +: HALF] <= '0;
        dirQ[h*HALF +: HALF] <= '0;
      end else begin
        if (strobe.wrHalf[h])
          lvlQ[h*HALF +: HALF] <= (lvlQ[h*HALF +: HALF] & ~wMask) | (wVal & wMask);
        if (strobe.wrHalf[2+h])
          dirQ[h*HALF +: HALF] <= (dirQ[h*HALF +: HALF] & ~wMask) | (wVal & wMask);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_LVL_LO: busRdata = {16'h0, lvlQ[HALF-1:0]};
      SEL_LVL_HI: busRdata = {16'h0, lvlQ[PINS-1:HALF]};
      SEL_DIR_LO: busRdata = {16'h0, dirQ[HALF-1:0]};
      SEL_DIR_HI: busRdata = {16'h0, dirQ[PINS-1:HALF]};
      SEL_PORT:   busRdata = syncB;
      SEL_IDENT:  busRdata = VERSION_ID;
      default:    busRdata = '0;
    endcase
  end

  // R5: no write strobe means no state change
  a_r5_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrHalf == '0) |=> ($stable(lvlQ) && $stable(dirQ)));
  // R2: unmasked bits of the low level half survive a write
  a_r2_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrHalf[0] && wMask == '0) |=> $stable(lvlQ));
  // R3: a write to the high level half leaves the low half alone
  a_r3_half_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrHalf[1] |=> $stable(lvlQ[HALF-1:0]));
  // R8: the port word lags the pads by two flops
  a_r8_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> syncB == $past(padIn, 2));
  // R9: the identifier is nonzero
  initial a_r9_ident_nonzero: assert (VERSION_ID != 32'h0);
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_mask_pkg::*;
#(
  parameter logic [31:0] VERSION_ID = 32'h0101_157C
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  input  logic        busWe,
  output logic [31:0] busRdata,
  input  logic [31:0] padIn,
  output logic [31:0] padOut,
  output logic [31:0] padOe
);
  ctrlStrobe_t     strobe;
  logic [PINS-1:0] lvlQ, dirQ;

  gpio_mask_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe), .strobe(strobe)
  );

  gpio_mask_datapath #(.VERSION_ID(VERSION_ID)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .busWdata(busWdata),
    .padIn(padIn), .busRdata(busRdata), .lvlQ(lvlQ), .dirQ(dirQ)
  );

  assign padOut = lvlQ;
  assign padOe  = dirQ;

  // R6/R1: pads are quiet right after reset release
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (padOe == '0 && padOut == '0));
endmodule

// File: tb/sim_gpio_mask_bank.sv
`timescale 1ns/1ps
module sim_gpio_mask_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  busAddr = 0;
  logic [31:0] busWdata = 0;
  logic        busWe = 0;
  logic [31:0] busRdata;
  logic [31:0] padIn = 0;
  logic [31:0] padOut, padOe;
  int nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  gpio_mask_bank u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk); busWe = 0; busAddr = 8'hFF;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 padOut", padOut, 0);
    chk("R1 padOe", padOe, 0);
    rd(8'h08, d); chk("R1 dirLo", d, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(8'h00, 32'h00FF_00A5);
    chk("R2 lo level", padOut, 32'h0000_00A5);
    wr(8'h04, 32'h8001_FFFF);
    chk("R3 hi level", padOut, 32'h8001_00A5);
    rd(8'h04, d); chk("R7 readback hi", d, 32'h0000_8001);
    rd(8'h00, d); chk("R7 readback lo", d, 32'h0000_00A5);
  endtask

  task automatic t_mask;
    wr(8'h00, 32'h0003_0002);
    chk("R5 partial mask", padOut, 32'h8001_00A6);
    wr(8'h00, 32'h0000_FFFF);
    chk("R5 zero mask", padOut, 32'h8001_00A6);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_1234);
    wr(8'h0C, 32'h0F00_0A00);
    chk("R4 dir", padOe, 32'h0A00_1234);
    chk("R6 out kept", padOut, 32'h8001_00A6);
    rd(8'h0C, d); chk("R7 dir hi read", d, 32'h0000_0A00);
  endtask

  task automatic t_port;
    logic [31:0] d;
    @(negedge clk); padIn = 32'hDEAD_BEEF; busAddr = 8'h70;
    @(negedge clk); #1 chk("R8 not after 1 edge", busRdata, 0);
    @(negedge clk); #1 chk("R8 after 2 edges", busRdata, 32'hDEAD_BEEF);
    rd(8'h78, d); chk("R9 ident", d, 32'h0101_157C);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h10, d); chk("R10 unmapped read", d, 0);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    chk("R10 out unchanged", padOut, 32'h8001_00A6);
    chk("R10 oe unchanged", padOe, 32'h0A00_1234);
    rd(8'h78, d); chk("R10 ident kept", d, 32'h0101_157C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_level();
    t_mask();
    t_dir();
    t_port();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #100000;
    nRun++; nFail++;
    $display("FAIL watchdog");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule